// File: doc/BRIEF.md
# Two-Level Linear-to-Physical Address Walker

This block turns a 32-bit linear address into a physical address. It reads a directory entry and then a table entry from memory, checks the access rights that both entries grant, and returns either the physical address or a fault. Each request carries a linear address, a write flag and a user flag. A 20-bit directory frame input gives the physical page that holds the directory. Two enable inputs decide whether translation happens at all.

The walker uses a word-wide memory master port to fetch entries. On a successful walk it also writes entries back to set their usage flags. It handles one request at a time: it accepts a request, performs the walk, and raises a one-cycle response that gives the physical address or the fault cause together with the faulting linear address. Entry bits that the walker does not interpret pass through the write-backs unchanged.

Top module: `lin2phys_walker`

## Requirements
- R1: When `ctl_paging` is 0, or `ctl_protect` is 0, the response carries `rsp_paddr` equal to the request's linear address and `rsp_fault` = 0, and no memory access is made.
- R2: The linear address splits into three fields: directory index = bits 31:22, table index = bits 21:12, offset = bits 11:0. The walker reads the directory entry at `{dir_frame, dir_index, 2'b00}`. It then reads the table entry at `{dir_entry[31:12], table_index, 2'b00}`. A successful walk returns `{table_entry[31:12], offset}`.
- R3: If either entry has bit 0 (present) equal to 0, the access faults with `rsp_cause` = 1 (absent) and `rsp_fault_addr` = the linear address. A directory entry that is absent stops the walk before the table entry is read.
- R4: A user access (`req_user` = 1) faults with cause 3 (user-protect) when either entry has bit 2 equal to 0. This check takes priority over the write check.
- R5: A user write faults with cause 2 (write-protect) when either entry has bit 1 equal to 0. Supervisor accesses (`req_user` = 0) skip both the R4 and R5 checks. A response without a fault carries cause 0.
- R6: A faulting access performs no memory write.
- R7: On a successful walk, the walker sets bit 5 (accessed) in each entry that has it clear. On a write, it also sets bit 6 (dirty) in the table entry if that bit is clear. Each update is a read-modify-write that keeps every other bit of the entry. No write is issued for an entry whose bits are already set. The directory entry is written before the table entry.
- R8: `req_ready` is 1 only while idle, so no new request is accepted until the previous one has completed. `rsp_valid` is a single-cycle pulse.
- R9: The walker holds `mem_req` together with a stable address, write flag and write data until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_paging | input | 1 | Translation enable |
| ctl_protect | input | 1 | Protection enable; translation also needs this bit |
| dir_frame | input | 20 | Physical frame of the directory |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_laddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made at user level |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 2 | 0 none, 1 absent, 2 write-protect, 3 user-protect |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault_addr | output | 32 | Linear address of the request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench sweeps every combination of present, writable, user and accessed flags in the directory entry, and every combination of present, writable, user, accessed and dirty flags in the table entry, across all four access kinds.

- **Absent directory entry.** The bench checks that the table read is skipped. A walker that read the table anyway would show a second read address.
- **Cause priority.** Cases where the user and write checks both fail expose a walker that reports the wrong cause.
- **Writes on a faulting walk.** A walker that set the accessed flag before it knew whether the walk would fault would show a nonzero write count.
- **Stray writes.** Entries whose flags are already set expose a write-back that is always issued.
- **Dirty flag.** Supervisor writes to read-only pages expose a dirty flag that is missed or placed on the directory entry.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int LIN_W   = 32;
    localparam int DIR_W   = 10;
    localparam int TBL_W   = 10;
    localparam int OFF_W   = LIN_W - DIR_W - TBL_W;
    localparam int FRAME_W = LIN_W - OFF_W;
    localparam int ENT_W   = 32;
    localparam int LVLS    = 2;

    localparam int BIT_P  = 0;
    localparam int BIT_RW = 1;
    localparam int BIT_US = 2;
    localparam int BIT_A  = 5;
    localparam int BIT_D  = 6;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_RD_DIR = 3'd1,
        S_RD_TBL = 3'd2,
        S_WR_DIR = 3'd3,
        S_WR_TBL = 3'd4,
        S_RESP   = 3'd5
    } walk_st_e;

    typedef enum logic [1:0] {
        FC_NONE    = 2'd0,
        FC_ABSENT  = 2'd1,
        FC_WRPROT  = 2'd2,
        FC_USRPROT = 2'd3
    } fault_e;

    typedef struct packed {
        walk_st_e           st;
        logic [LIN_W-1:0]   laddr;
        logic               is_wr;
        logic               is_usr;
        logic [FRAME_W-1:0] frame;
        logic [ENT_W-1:0]   dent;
        logic [ENT_W-1:0]   dent_new;
        logic [ENT_W-1:0]   tent_new;
        logic               tent_need;
        logic               fault;
        fault_e             cause;
        logic [LIN_W-1:0]   paddr;
    } walk_ctx_t;
endpackage

// File: rtl/pgw_mode.sv
module pgw_mode (
    input  logic paging_i,
    input  logic protect_i,
    output logic xlate_on_o
);
    // translation needs both enables; paging without protection behaves as off
    always_comb begin
        xlate_on_o = paging_i & protect_i;
    end
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm
    import pgw_pkg::*;
(
    input  logic [2:0] dir_flags_i,
    input  logic [2:0] tbl_flags_i,
    input  logic       is_wr_i,
    input  logic       is_usr_i,
    output fault_e     cause_o
);
    logic both_present;
    logic both_user;
    logic both_writable;

    always_comb begin
        both_present  = dir_flags_i[BIT_P]  & tbl_flags_i[BIT_P];
        both_user     = dir_flags_i[BIT_US] & tbl_flags_i[BIT_US];
        both_writable = dir_flags_i[BIT_RW] & tbl_flags_i[BIT_RW];
        if (!both_present) begin
            cause_o = FC_ABSENT;
        end else if (is_usr_i && !both_user) begin
            cause_o = FC_USRPROT;
        end else if (is_usr_i && is_wr_i && !both_writable) begin
            cause_o = FC_WRPROT;
        end else begin
            cause_o = FC_NONE;
        end
    end
endmodule

// File: rtl/pgw_entry_upd.sv
module pgw_entry_upd
    import pgw_pkg::*;
(
    input  logic [ENT_W-1:0] ent_i,
    input  logic             mark_dirty_i,
    output logic [ENT_W-1:0] ent_o,
    output logic             need_o
);
    logic [ENT_W-1:0] set_mask;

    always_comb begin
        set_mask        = '0;
        set_mask[BIT_A] = 1'b1;
        set_mask[BIT_D] = mark_dirty_i;
        ent_o           = ent_i | set_mask;
        need_o          = (ent_o != ent_i);
    end
endmodule

// File: rtl/lin2phys_walker.sv
module lin2phys_walker
    import pgw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_paging,
    input  logic               ctl_protect,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [LIN_W-1:0]   req_laddr,
    input  logic               req_write,
    input  logic               req_user,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [1:0]         rsp_cause,
    output logic [LIN_W-1:0]   rsp_paddr,
    output logic [LIN_W-1:0]   rsp_fault_addr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [LIN_W-1:0]   mem_addr,
    output logic [ENT_W-1:0]   mem_wdata,
    input  logic               mem_ack,
    input  logic [ENT_W-1:0]   mem_rdata
);
    walk_ctx_t c_d, c_q;

    logic xlate_on;
    fault_e chk_cause;
    logic [LIN_W-1:0] dir_addr;
    logic [LIN_W-1:0] tbl_addr;
    logic [DIR_W-1:0] dir_idx;
    logic [TBL_W-1:0] tbl_idx;
    logic [OFF_W-1:0] pg_off;

    logic [ENT_W-1:0] upd_in   [LVLS];
    logic             upd_mark [LVLS];
    logic [ENT_W-1:0] upd_out  [LVLS];
    logic             upd_need [LVLS];

    pgw_mode u_mode (
        .paging_i   (ctl_paging),
        .protect_i  (ctl_protect),
        .xlate_on_o (xlate_on)
    );

    pgw_perm u_perm (
        .dir_flags_i (c_q.dent[2:0]),
        .tbl_flags_i (mem_rdata[2:0]),
        .is_wr_i     (c_q.is_wr),
        .is_usr_i    (c_q.is_usr),
        .cause_o     (chk_cause)
    );

    // level 0 = directory entry (held), level 1 = table entry (arriving)
    always_comb begin
        upd_in[0]   = c_q.dent;
        upd_mark[0] = 1'b0;
        upd_in[1]   = mem_rdata;
        upd_mark[1] = c_q.is_wr;
    end

    for (genvar g = 0; g < LVLS; g++) begin : g_upd
        pgw_entry_upd u_upd (
            .ent_i        (upd_in[g]),
            .mark_dirty_i (upd_mark[g]),
            .ent_o        (upd_out[g]),
            .need_o       (upd_need[g])
        );
    end

    always_comb begin
        dir_idx  = c_q.laddr[LIN_W-1 -: DIR_W];
        tbl_idx  = c_q.laddr[OFF_W +: TBL_W];
        pg_off   = c_q.laddr[OFF_W-1:0];
        dir_addr = {c_q.frame, dir_idx, 2'b00};
        tbl_addr = {c_q.dent[ENT_W-1 -: FRAME_W], tbl_idx, 2'b00};
    end

    always_comb begin
        c_d       = c_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (c_q.st)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    c_d.laddr     = req_laddr;
                    c_d.is_wr     = req_write;
                    c_d.is_usr    = req_user;
                    c_d.frame     = dir_frame;
                    c_d.fault     = 1'b0;
                    c_d.cause     = FC_NONE;
                    c_d.tent_need = 1'b0;
                    c_d.paddr     = req_laddr;
                    c_d.st        = xlate_on ? S_RD_DIR : S_RESP;
                end
            end
            S_RD_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
                if (mem_ack) begin
                    c_d.dent = mem_rdata;
                    if (!mem_rdata[BIT_P]) begin
                        c_d.fault = 1'b1;
                        c_d.cause = FC_ABSENT;
                        c_d.st    = S_RESP;
                    end else begin
                        c_d.st = S_RD_TBL;
                    end
                end
            end
            S_RD_TBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
                if (mem_ack) begin
                    if (chk_cause != FC_NONE) begin
                        c_d.fault = 1'b1;
                        c_d.cause = chk_cause;
                        c_d.st    = S_RESP;
                    end else begin
                        c_d.paddr     = {mem_rdata[ENT_W-1 -: FRAME_W], pg_off};
                        c_d.dent_new  = upd_out[0];
                        c_d.tent_new  = upd_out[1];
                        c_d.tent_need = upd_need[1];
                        if (upd_need[0]) begin
                            c_d.st = S_WR_DIR;
                        end else if (upd_need[1]) begin
                            c_d.st = S_WR_TBL;
                        end else begin
                            c_d.st = S_RESP;
                        end
                    end
                end
            end
            S_WR_DIR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = c_q.dent_new;
                if (mem_ack) begin
                    c_d.st = c_q.tent_need ? S_WR_TBL : S_RESP;
                end
            end
            S_WR_TBL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = c_q.tent_new;
                if (mem_ack) begin
                    c_d.st = S_RESP;
                end
            end
            S_RESP: begin
                rsp_valid = 1'b1;
                c_d.st    = S_IDLE;
            end
            default: begin
                c_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        rsp_fault      = c_q.fault;
        rsp_cause      = c_q.cause;
        rsp_paddr      = c_q.paddr;
        rsp_fault_addr = c_q.laddr;
    end
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [1:0]  rsp_cause,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata
);
    logic wrote_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrote_q <= 1'b0;
        end else if (rsp_valid) begin
            wrote_q <= 1'b0;
        end else if (mem_req && mem_we && mem_ack) begin
            wrote_q <= 1'b1;
        end
    end

    assert_busy_blocks_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    assert_rsp_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_wb_sets_accessed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[5]);

    assert_fault_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_cause != 2'd0));

    assert_ok_has_no_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0));

    assert_no_write_on_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !wrote_q);
endmodule

bind lin2phys_walker pgw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/lin2phys_walker_bench.sv
module lin2phys_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_paging = 1'b0;
    logic        ctl_protect = 1'b0;
    logic [19:0] dir_frame = 20'h00001;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_fault_addr;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:4095];
    int rd_total = 0;
    int wr_total = 0;
    logic [31:0] rd_last = '0;
    logic [31:0] rd_prev = '0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic got_fault;
    logic [1:0] got_cause;
    logic [31:0] got_paddr;
    logic [31:0] got_faddr;
    logic got_rsp;

    lin2phys_walker u_lin2phys_walker (
        .clk(clk), .rst_n(rst_n), .ctl_paging(ctl_paging), .ctl_protect(ctl_protect),
        .dir_frame(dir_frame), .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_paddr(rsp_paddr), .rsp_fault_addr(rsp_fault_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    // memory responder: acknowledges one cycle after a request
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                wr_total <= wr_total + 1;
            end else begin
                mem_rdata <= mem[mem_addr[13:2]];
                rd_total <= rd_total + 1;
                rd_prev <= rd_last;
                rd_last <= mem_addr;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] la, input logic wr, input logic usr);
        int t;
        @(negedge clk);
        req_laddr = la;
        req_write = wr;
        req_user = usr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 100) begin
            @(negedge clk);
            t++;
        end
        got_rsp = rsp_valid;
        got_fault = rsp_fault;
        got_cause = rsp_cause;
        got_paddr = rsp_paddr;
        got_faddr = rsp_fault_addr;
        if (!got_rsp) begin
            check(1'b0, "R8", "response timeout", 32'h0, 32'h1);
        end
    endtask

    initial begin
        int rd0, wr0;
        logic [31:0] la;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R8", "reset ready", {31'b0, req_ready}, 32'h1);
        check(rsp_valid == 1'b0, "R8", "reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check(mem_req == 1'b0, "R9", "reset mem_req", {31'b0, mem_req}, 32'h0);
        rst_n = 1'b1;

        // R1: translation off in three enable combinations
        for (int m = 0; m < 3; m++) begin
            for (int k = 0; k < 4; k++) begin
                ctl_paging  = (m == 1);
                ctl_protect = (m == 0);
                la = 32'h1234_5678 * (k + 1) + m;
                rd0 = rd_total;
                wr0 = wr_total;
                issue(la, k[0], k[1]);
                check(got_fault == 1'b0, "R1", "fault when off", {31'b0, got_fault}, 32'h0);
                check(got_paddr == la, "R1", "paddr when off", got_paddr, la);
                check(rd_total == rd0 && wr_total == wr0, "R1", "mem access when off",
                      rd_total - rd0 + wr_total - wr0, 32'h0);
            end
        end

        ctl_paging = 1'b1;
        ctl_protect = 1'b1;
        for (int pd = 0; pd < 16; pd++) begin
            for (int pt = 0; pt < 32; pt++) begin
                for (int rq = 0; rq < 4; rq++) begin
                    int n;
                    logic [9:0] di, ti;
                    logic [11:0] off;
                    logic [31:0] dent, tent, dexp, texp, dadr, tadr;
                    logic wr, usr;
                    logic [1:0] ecause;
                    int ewr;
                    n = pd * 128 + pt * 4 + rq;
                    di = 10'((n * 37) % 1024);
                    ti = 10'((n * 91) % 1024);
                    off = 12'((n * 13) % 4096);
                    wr = rq[0];
                    usr = rq[1];
                    dent = 32'h0000_2000 | {31'b0, pd[0]} | {30'b0, pd[1], 1'b0}
                         | {29'b0, pd[2], 2'b0} | {26'b0, pd[3], 5'b0};
                    tent = {20'h00100 + 20'(n), 12'h218} | {31'b0, pt[0]} | {30'b0, pt[1], 1'b0}
                         | {29'b0, pt[2], 2'b0} | {26'b0, pt[3], 5'b0} | {25'b0, pt[4], 6'b0};
                    dadr = 32'h0000_1000 + {20'b0, di, 2'b00};
                    tadr = 32'h0000_2000 + {20'b0, ti, 2'b00};
                    mem[dadr[13:2]] = dent;
                    mem[tadr[13:2]] = tent;
                    la = {di, ti, off};
                    if (!dent[0] || !tent[0]) ecause = 2'd1;
                    else if (usr && (!dent[2] || !tent[2])) ecause = 2'd3;
                    else if (usr && wr && (!dent[1] || !tent[1])) ecause = 2'd2;
                    else ecause = 2'd0;
                    if (ecause == 2'd0) begin
                        dexp = dent | 32'h20;
                        texp = tent | 32'h20 | (wr ? 32'h40 : 32'h0);
                    end else begin
                        dexp = dent;
                        texp = tent;
                    end
                    ewr = (dexp != dent ? 1 : 0) + (texp != tent ? 1 : 0);
                    rd0 = rd_total;
                    wr0 = wr_total;
                    issue(la, wr, usr);
                    case (ecause)
                        2'd1: check(got_cause == 2'd1 && got_fault, "R3", "absent cause", {30'b0, got_cause}, 32'd1);
                        2'd3: check(got_cause == 2'd3 && got_fault, "R4", "user cause", {30'b0, got_cause}, 32'd3);
                        2'd2: check(got_cause == 2'd2 && got_fault, "R5", "write cause", {30'b0, got_cause}, 32'd2);
                        default: check(got_cause == 2'd0 && !got_fault, "R5", "no fault", {30'b0, got_cause}, 32'd0);
                    endcase
                    if (ecause != 2'd0) begin
                        check(got_faddr == la, "R3", "fault address", got_faddr, la);
                        check(wr_total == wr0, "R6", "writes on fault", wr_total - wr0, 32'd0);
                    end else begin
                        check(got_paddr == {tent[31:12], off}, "R2", "paddr", got_paddr, {tent[31:12], off});
                        check(wr_total - wr0 == ewr, "R7", "write count", wr_total - wr0, ewr);
                    end
                    if (!dent[0]) begin
                        check(rd_total - rd0 == 1 && rd_last == dadr, "R3", "table read skipped", rd_last, dadr);
                    end else begin
                        check(rd_total - rd0 == 2 && rd_prev == dadr && rd_last == tadr, "R2",
                              "entry read addresses", rd_last, tadr);
                    end
                    check(mem[dadr[13:2]] == dexp, "R7", "directory entry after", mem[dadr[13:2]], dexp);
                    check(mem[tadr[13:2]] == texp, "R7", "table entry after", mem[tadr[13:2]], texp);
                end
            end
        end

        // R8: ready after a completed walk
        @(negedge clk);
        check(req_ready == 1'b1, "R8", "ready after walk", {31'b0, req_ready}, 32'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        checks++;
        fails++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule